// File: doc/BRIEF.md
# Double-Buffered PWM Timer Channel

This block is a single down-counting timer channel that drives a pulse-width modulated level and a one-cycle interrupt strobe. Software loads a period value and a threshold value into two shadow buffers whenever it likes. Those writes never disturb the running counter or the active threshold. The buffers reach the active registers only in two ways: a manual-load control bit, or an automatic reload each time the counter expires. A duty-cycle change is therefore made by rewriting only the threshold buffer, and it takes effect cleanly at the next period boundary.

The counter moves only on cycles where the tick-enable input from the clock tree is high. A four-bit control word sets four things: whether the channel runs, whether the buffers are being force-loaded, the output polarity, and whether the channel repeats or fires once. The usual programming sequence has two steps. First, write the buffers and set manual-load together with auto-reload. Second, set the run bit and clear manual-load in the same write. A build parameter removes the output pin, so the same channel can serve as a pure periodic tick source.

Register writes are single-cycle strobes with no back-pressure. Each strobe is accepted on the clock edge where it is high, so the block has no valid/ready handshake.

Top module: `pwm_dbuf_channel`

## Requirements
- R1: After reset, the active count, active threshold, every buffer and every control bit are zero, `irq_pulse` is low, and with the output pin present `pwm_out` is high (count 0 is at or below threshold 0).
- R2: A write to the period buffer or the threshold buffer leaves `cur_count` and `cur_compare` unchanged on the following cycles, until a manual load or a reload happens.
- R3: While control bit 1 (manual load) is set, each cycle copies both buffers into the active count and active threshold, and the count does not decrement even when `tick` is high.
- R4: With control bit 0 (run) set and bit 1 clear, a cycle with `tick` high and a nonzero count lowers `cur_count` by one at the next edge. A cycle with `tick` low leaves it unchanged.
- R5: A cycle with run set, manual load clear, `tick` high and count zero is an expiry. `irq_pulse` is high during the single cycle after that edge.
- R6: On an expiry with control bit 3 (auto-reload) set, both buffers are copied into the active registers. A threshold buffer written mid-period shows on `cur_compare` only after that reload.
- R7: On an expiry with auto-reload clear, the count stays at zero and the run bit clears, so no further interrupt follows.
- R8: Clearing the run bit freezes `cur_count` regardless of `tick`.
- R9: `pwm_out` equals (`cur_count` <= `cur_compare`) XOR control bit 2 (invert).
- R10: With `HAS_OUTPUT` = 0, `pwm_out` is constantly low, while count, threshold and interrupt behave exactly as with the pin present.
- R11: A control write arriving in the same cycle as an expiry without auto-reload takes precedence over the hardware clear of the run bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable from the clock tree |
| period_we | input | 1 | Write strobe for the period buffer |
| period_wdata | input | WIDTH | Period buffer value |
| thresh_we | input | 1 | Write strobe for the threshold buffer |
| thresh_wdata | input | WIDTH | Threshold buffer value |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 4 | Control word: [0] run, [1] manual load, [2] invert, [3] auto-reload |
| cur_count | output | WIDTH | Active down-counter value |
| cur_compare | output | WIDTH | Active threshold value |
| pwm_out | output | 1 | Modulated output level |
| irq_pulse | output | 1 | One-cycle expiry strobe |

## Verification
The bench builds two copies from the same stimulus. One uses the default 16-bit width with the output pin present; the other sets `HAS_OUTPUT` to 0. This puts the polarity and compare behaviour of the pin and its removed variant side by side, cycle by cycle. Small period values are used so that many expiries, reloads, mid-period threshold changes and the collision between a control write and a one-shot expiry all occur within a short run. The wide end of the 16-bit range is exercised only through buffer writes that must not reach the active registers.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  localparam int CTRL_W    = 4;
  localparam int RUN_BIT   = 0;
  localparam int LOAD_BIT  = 1;
  localparam int INV_BIT   = 2;
  localparam int RLD_BIT   = 3;

  // Field order follows the control word bit positions (bit 3 first).
  typedef struct packed {
    logic reload;
    logic invert;
    logic load;
    logic run;
  } chan_ctrl_t;
endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_chan_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              period_we,
  input  logic [WIDTH-1:0]  period_wdata,
  input  logic              thresh_we,
  input  logic [WIDTH-1:0]  thresh_wdata,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              halt_req,
  output logic [WIDTH-1:0]  period_buf,
  output logic [WIDTH-1:0]  thresh_buf,
  output chan_ctrl_t        ctrl
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_buf <= '0;
      thresh_buf <= '0;
    end else begin
      if (period_we) period_buf <= period_wdata;
      if (thresh_we) thresh_buf <= thresh_wdata;
    end
  end

  // A software write wins over the hardware clear of the run bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (ctrl_we) begin
      ctrl.run    <= ctrl_wdata[RUN_BIT];
      ctrl.load   <= ctrl_wdata[LOAD_BIT];
      ctrl.invert <= ctrl_wdata[INV_BIT];
      ctrl.reload <= ctrl_wdata[RLD_BIT];
    end else if (halt_req) begin
      ctrl.run <= 1'b0;
    end
  end

  // R7
  halt_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !ctrl_we) |=> !ctrl.run);

  // R11
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl.run == $past(ctrl_wdata[RUN_BIT])));

endmodule

// File: rtl/pwm_down_counter.sv
module pwm_down_counter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             load,
  input  logic             reload,
  input  logic [WIDTH-1:0] period_buf,
  input  logic [WIDTH-1:0] thresh_buf,
  output logic [WIDTH-1:0] count_q,
  output logic [WIDTH-1:0] compare_q,
  output logic             irq_q,
  output logic             halt_req
);

  logic active_tick;
  logic at_zero;
  logic expire;

  assign active_tick = run && !load && tick;
  assign at_zero     = (count_q == '0);
  assign expire      = active_tick && at_zero;
  assign halt_req    = expire && !reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      compare_q <= '0;
    end else if (load || (expire && reload)) begin
      count_q   <= period_buf;
      compare_q <= thresh_buf;
    end else if (active_tick && !at_zero) begin
      count_q   <= count_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= expire;
  end

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(run && tick)) |=> ($stable(count_q) && $stable(compare_q)));

  // R3
  load_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count_q == $past(period_buf) && compare_q == $past(thresh_buf)));

  // R4
  decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && tick && count_q != '0) |=> (count_q == $past(count_q) - 1'b1));

  // R5
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ($past(count_q) == '0 && $past(run) && $past(tick)));

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int WIDTH      = 16,
  parameter bit HAS_OUTPUT = 1'b1
) (
  input  logic [WIDTH-1:0] count_q,
  input  logic [WIDTH-1:0] compare_q,
  input  logic             invert,
  output logic             pwm_out
);

  generate
    if (HAS_OUTPUT) begin : g_pin
      logic at_or_below;
      assign at_or_below = (count_q <= compare_q);
      assign pwm_out     = at_or_below ^ invert;
    end else begin : g_no_pin
      logic unused_in;
      assign unused_in = ^{count_q, compare_q, invert};
      assign pwm_out   = 1'b0 & unused_in;
    end
  endgenerate

endmodule

// File: rtl/pwm_dbuf_channel.sv
module pwm_dbuf_channel
  import pwm_chan_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter bit HAS_OUTPUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              period_we,
  input  logic [WIDTH-1:0]  period_wdata,
  input  logic              thresh_we,
  input  logic [WIDTH-1:0]  thresh_wdata,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [WIDTH-1:0]  cur_count,
  output logic [WIDTH-1:0]  cur_compare,
  output logic              pwm_out,
  output logic              irq_pulse
);

  chan_ctrl_t       ctrl;
  logic [WIDTH-1:0] period_buf;
  logic [WIDTH-1:0] thresh_buf;
  logic             halt_req;

  pwm_shadow_regs #(.WIDTH(WIDTH)) u_shadow (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_we    (period_we),
    .period_wdata (period_wdata),
    .thresh_we    (thresh_we),
    .thresh_wdata (thresh_wdata),
    .ctrl_we      (ctrl_we),
    .ctrl_wdata   (ctrl_wdata),
    .halt_req     (halt_req),
    .period_buf   (period_buf),
    .thresh_buf   (thresh_buf),
    .ctrl         (ctrl)
  );

  pwm_down_counter #(.WIDTH(WIDTH)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .run        (ctrl.run),
    .load       (ctrl.load),
    .reload     (ctrl.reload),
    .period_buf (period_buf),
    .thresh_buf (thresh_buf),
    .count_q    (cur_count),
    .compare_q  (cur_compare),
    .irq_q      (irq_pulse),
    .halt_req   (halt_req)
  );

  pwm_out_stage #(.WIDTH(WIDTH), .HAS_OUTPUT(HAS_OUTPUT)) u_out (
    .count_q   (cur_count),
    .compare_q (cur_compare),
    .invert    (ctrl.invert),
    .pwm_out   (pwm_out)
  );

  // R8
  frozen_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !ctrl.load) |=> $stable(cur_count));

endmodule

// File: tb/tb_pwm_dbuf_channel.sv
module tb_pwm_dbuf_channel;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic period_we = 1'b0, thresh_we = 1'b0, ctrl_we = 1'b0;
  logic [W-1:0] period_wdata = '0, thresh_wdata = '0;
  logic [3:0] ctrl_wdata = '0;
  logic [W-1:0] cnt_a, cmp_a, cnt_b, cmp_b;
  logic pwm_a, pwm_b, irq_a, irq_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_dbuf_channel #(.WIDTH(W), .HAS_OUTPUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .period_we(period_we), .period_wdata(period_wdata),
    .thresh_we(thresh_we), .thresh_wdata(thresh_wdata),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .cur_count(cnt_a), .cur_compare(cmp_a), .pwm_out(pwm_a), .irq_pulse(irq_a));

  pwm_dbuf_channel #(.WIDTH(W), .HAS_OUTPUT(1'b0)) dut_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .period_we(period_we), .period_wdata(period_wdata),
    .thresh_we(thresh_we), .thresh_wdata(thresh_wdata),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .cur_count(cnt_b), .cur_compare(cmp_b), .pwm_out(pwm_b), .irq_pulse(irq_b));

  int checks = 0, errors = 0, irq_seen = 0;
  bit live = 1'b0;

  // Behavioural reference state
  int m_cnt = 0, m_cmp = 0, m_pbuf = 0, m_tbuf = 0;
  bit m_run = 0, m_load = 0, m_inv = 0, m_rld = 0, m_irq = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      bit halt;
      halt = 0;
      m_irq = 0;
      if (m_load) begin
        m_cnt = m_pbuf; m_cmp = m_tbuf;
      end else if (m_run && tick) begin
        if (m_cnt == 0) begin
          m_irq = 1;
          if (m_rld) begin m_cnt = m_pbuf; m_cmp = m_tbuf; end
          else halt = 1;
        end else m_cnt = m_cnt - 1;
      end
      if (period_we) m_pbuf = int'(period_wdata);
      if (thresh_we) m_tbuf = int'(thresh_wdata);
      if (ctrl_we) begin
        m_run = ctrl_wdata[0]; m_load = ctrl_wdata[1];
        m_inv = ctrl_wdata[2]; m_rld = ctrl_wdata[3];
      end else if (halt) m_run = 0;
    end
  end

  // Cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (live) begin
      int exp_pwm;
      exp_pwm = ((m_cnt <= m_cmp) ? 1 : 0) ^ int'(m_inv);
      if (irq_a) irq_seen++;
      check(int'(cnt_a) == m_cnt, "R4 count", int'(cnt_a), m_cnt);
      check(int'(cmp_a) == m_cmp, "R6 compare", int'(cmp_a), m_cmp);
      check(int'(irq_a) == int'(m_irq), "R5 irq", int'(irq_a), int'(m_irq));
      check(int'(pwm_a) == exp_pwm, "R9 pwm", int'(pwm_a), exp_pwm);
      check(pwm_b == 1'b0, "R10 pwm absent", int'(pwm_b), 0);
      check(cnt_b == cnt_a && irq_b == irq_a && cmp_b == cmp_a,
            "R10 tick-only copy", int'(cnt_b), int'(cnt_a));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [3:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic wr_bufs(input int p, input int t);
    period_we = 1'b1; period_wdata = W'(p);
    thresh_we = 1'b1; thresh_wdata = W'(t);
    @(negedge clk);
    period_we = 1'b0; thresh_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    // R1 reset state
    check(cnt_a == 0 && cmp_a == 0, "R1 active regs", int'(cnt_a), 0);
    check(irq_a == 1'b0, "R1 irq", int'(irq_a), 0);
    check(pwm_a == 1'b1, "R1 pwm", int'(pwm_a), 1);
    rst_n = 1'b1;
    live = 1'b1;
    cyc(2);

    // R2 buffer writes do not reach the active registers
    wr_bufs(16'hFFFF, 16'hFFFE);
    tick = 1'b1;
    cyc(3);
    check(cnt_a == 0 && cmp_a == 0, "R2 buffers isolated", int'(cnt_a), 0);
    wr_bufs(5, 2);
    cyc(2);
    check(cmp_a == 0, "R2 threshold isolated", int'(cmp_a), 0);

    // R3 manual load held with tick high: copies, no decrement
    wr_ctrl(4'b1010);
    cyc(3);
    check(cnt_a == 5 && cmp_a == 2, "R3 load copy", int'(cnt_a), 5);

    // R11 field positions: run + auto-reload, load cleared in the same write
    wr_ctrl(4'b1001);
    cyc(20);
    // sparse ticks
    for (int i = 0; i < 30; i++) begin
      tick = (i % 3 == 0);
      @(negedge clk);
    end
    tick = 1'b1;
    // R6 mid-period threshold change
    wr_bufs(5, 4);
    check(cmp_a == 2, "R6 threshold waits for reload", int'(cmp_a), 2);
    cyc(14);
    check(cmp_a == 4, "R6 threshold after reload", int'(cmp_a), 4);

    // R9 invert polarity
    wr_ctrl(4'b1101);
    cyc(15);

    // R8 run cleared freezes the count
    wr_ctrl(4'b1000);
    begin
      logic [W-1:0] held;
      held = cnt_a;
      cyc(8);
      check(cnt_a == held, "R8 frozen", int'(cnt_a), int'(held));
    end

    // R7 one-shot: stops at zero with a single interrupt
    wr_bufs(3, 1);
    wr_ctrl(4'b0010);
    cyc(1);
    irq_seen = 0;
    wr_ctrl(4'b0001);
    cyc(12);
    check(cnt_a == 0, "R7 rests at zero", int'(cnt_a), 0);
    check(irq_seen == 1, "R7 single irq", irq_seen, 1);

    // R11 control write colliding with a one-shot expiry keeps run set
    wr_bufs(2, 0);
    wr_ctrl(4'b0010);
    wr_ctrl(4'b0001);
    while (cnt_a != 0) @(negedge clk);
    irq_seen = 0;
    wr_ctrl(4'b0001);
    cyc(4);
    check(irq_seen == 2, "R11 write wins over halt", irq_seen, 2);

    tick = 1'b0;
    cyc(3);
    live = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule